// File: doc/BRIEF.md
# Event Counter Unit with Overflow Interrupt

This block is a performance monitoring unit that counts selected events with eight 64-bit counters. Each counter picks one line out of a vector of up to 256 event inputs through an 8-bit event code. Code zero is tied to a constant one, so a counter with that code counts clock cycles. A counter advances only while three things are true: the global run bit is set, its own enable bit is set, and the event it selects is asserted.

Software reaches the unit over a simple 32-bit register bus. Each counter appears as two 32-bit words that can be read and written, so software can preload a counter, for example to place it near the wrap point. When a counter wraps from all ones to zero, it sets a sticky status flag. Software clears these flags with a write-one-to-clear register. A single interrupt line reports any flag whose mask bit is clear. The unit also holds a power-management override bit, which leaves the block as a level, and a read-only version word.

Top module: `evt_pmu`

## Requirements
- R1: Counter n (0..7) is 64 bits wide. Its low word sits at byte address 0x1d00 + 8*n and its high word at 0x1d04 + 8*n, and both words can be written and read back. A read issued with bus_rd in one cycle returns its data on bus_rdata, with bus_rvalid high, in the next cycle.
- R2: A counter increments by one at a clock edge when bit 0 of the register at 0x1c00 is 1, bit n of the enable register at 0x1c04 is 1, and its selected event is high. Code 0 selects a constant 1. Code c>0 selects evt_in[c].
- R3: Event codes are 8 bits wide. Counters 0..3 take their codes from the register at 0x1c80, and counters 4..7 from the register at 0x1c84. Counter n uses bits [8*(n mod 4)+7 : 8*(n mod 4)].
- R4: While bit 0 of 0x1c00 is 0, or while a counter's enable bit is 0, that counter holds its value no matter what the events do.
- R5: At the edge where counter n wraps from all ones to zero, bit n of the status register at 0x1c78 becomes 1 and stays set.
- R6: Writing 1 to bit n of 0x1c7c clears status bit n. Writing 0 leaves the bit unchanged. The register reads as 0. A wrap in the same cycle as a clear leaves the bit set.
- R7: A 1 in bit n of the mask register at 0x1c70 masks counter n, and the mask resets to 0xFF. irq_o is registered: after each edge it equals the OR over n of status[n] AND NOT mask[n], using the values held before that edge.
- R8: When a bus write to a counter word lands in the same cycle as an increment of that counter, the written word takes the written value and the other word is left unchanged.
- R9: Bit 9 of the register at 0x0534 is stored and drives pm_hold_o. The other bits of that register read as 0.
- R10: The register at 0x1cf0 always reads the VERSION parameter, and writes to it have no effect.
- R11: After reset, all counters and registers are 0 except the mask, which is 0xFF. irq_o, pm_hold_o and bus_rvalid are 0, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_EVT | Event lines; bit 0 is replaced by a constant one |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| bus_rvalid | output | 1 | High in the cycle bus_rdata carries read data |
| irq_o | output | 1 | Registered OR of unmasked overflow flags |
| pm_hold_o | output | 1 | Power-management override level |

## Verification
Assertions run on every cycle and cover the following:
- a counter holds its value when it has no increment and no write, and advances by exactly one when it has an increment and no write;
- a written word takes the bus data;
- a wrap sets its status bit, even against a same-cycle clear;
- a clear with no wrap removes its bit;
- irq_o follows the unmasked flags one cycle later;
- every read produces a valid response.

The bench keeps a cycle-accurate reference model of every counter and register, driven by random traffic with a fixed seed. Only its scenarios can show four things: the select fields are decoded at the right bit positions, each counter picks the right event line, preloading works across both words, and the global and per-counter gates combine correctly.

// File: rtl/evt_pmu_pkg.sv
package evt_pmu_pkg;
  localparam int DATA_W     = 32;
  localparam int FIELD_W    = 8;
  localparam int FIELDS_REG = DATA_W / FIELD_W;
  localparam int A_CTRL     = 'h1c00;
  localparam int A_ENABLE   = 'h1c04;
  localparam int A_MASK     = 'h1c70;
  localparam int A_STATUS   = 'h1c78;
  localparam int A_CLEAR    = 'h1c7c;
  localparam int A_SELECT   = 'h1c80;
  localparam int A_VERSION  = 'h1cf0;
  localparam int A_COUNT    = 'h1d00;
  localparam int A_CONFIG   = 'h0534;
  localparam int CNT_STRIDE = 8;
  localparam int PM_BIT     = 9;
endpackage

// File: rtl/evt_pmu_pick.sv
module evt_pmu_pick #(
  parameter int NUM_EVT = 256,
  parameter int FIELD_W = 8
) (
  input  logic [NUM_EVT-1:0] evt,
  input  logic [FIELD_W-1:0] code,
  output logic               hit
);
  localparam int EXT_W = 2 ** FIELD_W;
  logic [EXT_W-1:0] ext;

  assign ext = EXT_W'(evt);

  always_comb begin
    if (code == '0) hit = 1'b1;
    else            hit = ext[code];
  end
endmodule

// File: rtl/evt_pmu_slice.sv
module evt_pmu_slice #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam int HALF = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (wr_lo) cnt_q[HALF-1:0] <= wdata;
    else if (wr_hi) cnt_q[CNT_W-1:HALF] <= wdata;
    else if (inc)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign wrap = inc && !wr_lo && !wr_hi && (&cnt_q);

  // R2: an increment without a write advances by one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R4: no increment and no write keeps the value
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!inc && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  // R8: a bus write to the low word wins over an increment
  p_wr_lo_r8: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> cnt_q[HALF-1:0] == $past(wdata));
endmodule

// File: rtl/evt_pmu_ovf.sv
module evt_pmu_ovf #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] wrap,
  input  logic               clr_we,
  input  logic [NUM_CNT-1:0] clr_data,
  input  logic [NUM_CNT-1:0] mask,
  output logic [NUM_CNT-1:0] status_q,
  output logic               irq_q
);
  logic [NUM_CNT-1:0] clr_bits;

  assign clr_bits = clr_we ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_bits) | wrap;
      irq_q    <= |(status_q & ~mask);
    end
  end

  // R5: a wrap sets its flag, even against a same-cycle clear (R6)
  p_set_r5: assert property (@(posedge clk) disable iff (rst)
    (|wrap) |=> (status_q & $past(wrap)) == $past(wrap));
  // R6: a clear without a wrap removes its flag
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> (status_q & $past(clr_data & ~wrap)) == '0);
  // R6: with no clear and no wrap the flags hold
  p_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_we && wrap == '0) |=> $stable(status_q));
  // R7: the interrupt follows unmasked flags one cycle later
  p_irq_on_r7: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~mask) != '0) |=> irq_q);
  p_irq_off_r7: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~mask) == '0) |=> !irq_q);
endmodule

// File: rtl/evt_pmu.sv
module evt_pmu
  import evt_pmu_pkg::*;
#(
  parameter int          NUM_CNT = 8,
  parameter int          NUM_EVT = 256,
  parameter int          ADDR_W  = 16,
  parameter logic [31:0] VERSION = 32'h0001_0203
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic               irq_o,
  output logic               pm_hold_o
);
  localparam int CNT_W   = 2 * DATA_W;
  localparam int NUM_SEL = (NUM_CNT + FIELDS_REG - 1) / FIELDS_REG;

  logic                 run_q;
  logic [NUM_CNT-1:0]   enable_q;
  logic [NUM_CNT-1:0]   mask_q;
  logic [DATA_W-1:0]    sel_q [NUM_SEL];
  logic                 pm_q;
  logic [CNT_W-1:0]     cnt_q [NUM_CNT];
  logic [NUM_CNT-1:0]   wrap;
  logic [NUM_CNT-1:0]   status_q;
  logic [NUM_CNT-1:0]   hit;
  logic [NUM_CNT-1:0]   inc;
  logic [NUM_CNT-1:0]   wr_lo;
  logic [NUM_CNT-1:0]   wr_hi;
  logic                 clr_we;
  logic [DATA_W-1:0]    rd_mux;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  assign clr_we = bus_wr && at(bus_addr, A_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      enable_q <= '0;
      mask_q   <= '1;
      pm_q     <= 1'b0;
      for (int s = 0; s < NUM_SEL; s++) sel_q[s] <= '0;
    end else if (bus_wr) begin
      if (at(bus_addr, A_CTRL))   run_q    <= bus_wdata[0];
      if (at(bus_addr, A_ENABLE)) enable_q <= bus_wdata[NUM_CNT-1:0];
      if (at(bus_addr, A_MASK))   mask_q   <= bus_wdata[NUM_CNT-1:0];
      if (at(bus_addr, A_CONFIG)) pm_q     <= bus_wdata[PM_BIT];
      for (int s = 0; s < NUM_SEL; s++)
        if (at(bus_addr, A_SELECT + 4 * s)) sel_q[s] <= bus_wdata;
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic [FIELD_W-1:0] code;
    assign code     = sel_q[n / FIELDS_REG][FIELD_W * (n % FIELDS_REG) +: FIELD_W];
    assign wr_lo[n] = bus_wr && at(bus_addr, A_COUNT + CNT_STRIDE * n);
    assign wr_hi[n] = bus_wr && at(bus_addr, A_COUNT + CNT_STRIDE * n + 4);
    assign inc[n]   = run_q && enable_q[n] && hit[n];

    evt_pmu_pick #(.NUM_EVT(NUM_EVT), .FIELD_W(FIELD_W)) u_pick (
      .evt  (evt_in),
      .code (code),
      .hit  (hit[n])
    );

    evt_pmu_slice #(.CNT_W(CNT_W)) u_slice (
      .clk   (clk),
      .rst   (rst),
      .inc   (inc[n]),
      .wr_lo (wr_lo[n]),
      .wr_hi (wr_hi[n]),
      .wdata (bus_wdata),
      .cnt_q (cnt_q[n]),
      .wrap  (wrap[n])
    );
  end

  evt_pmu_ovf #(.NUM_CNT(NUM_CNT)) u_ovf (
    .clk      (clk),
    .rst      (rst),
    .wrap     (wrap),
    .clr_we   (clr_we),
    .clr_data (bus_wdata[NUM_CNT-1:0]),
    .mask     (mask_q),
    .status_q (status_q),
    .irq_q    (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (at(bus_addr, A_CTRL))    rd_mux = DATA_W'(run_q);
    if (at(bus_addr, A_ENABLE))  rd_mux = DATA_W'(enable_q);
    if (at(bus_addr, A_MASK))    rd_mux = DATA_W'(mask_q);
    if (at(bus_addr, A_STATUS))  rd_mux = DATA_W'(status_q);
    if (at(bus_addr, A_VERSION)) rd_mux = VERSION;
    if (at(bus_addr, A_CONFIG))  rd_mux = DATA_W'(pm_q) << PM_BIT;
    for (int s = 0; s < NUM_SEL; s++)
      if (at(bus_addr, A_SELECT + 4 * s)) rd_mux = sel_q[s];
    for (int n = 0; n < NUM_CNT; n++) begin
      if (at(bus_addr, A_COUNT + CNT_STRIDE * n))     rd_mux = cnt_q[n][DATA_W-1:0];
      if (at(bus_addr, A_COUNT + CNT_STRIDE * n + 4)) rd_mux = cnt_q[n][CNT_W-1:DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign pm_hold_o = pm_q;

  // R1: every read is answered in the next cycle
  p_rvalid_r1: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  // R10: the version word never changes
  p_version_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && at(bus_addr, A_VERSION)) |=> bus_rdata == VERSION);
  // R11: no response without a request
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
endmodule

// File: tb/evt_pmu_tb.sv
module evt_pmu_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] VER = 32'h0001_0203;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [255:0] evt_in = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [15:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic         irq_o;
  logic         pm_hold_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  longint unsigned m_cnt [8];
  bit [7:0]  m_en, m_mask, m_st;
  bit [31:0] m_sel [2];
  bit        m_run, m_pm, m_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  evt_pmu #(.VERSION(VER)) u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_o(irq_o), .pm_hold_o(pm_hold_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] model_read(input bit [15:0] a);
    bit [31:0] v = '0;
    case (a)
      16'h1c00: v = {31'd0, m_run};
      16'h1c04: v = {24'd0, m_en};
      16'h1c70: v = {24'd0, m_mask};
      16'h1c78: v = {24'd0, m_st};
      16'h1c80: v = m_sel[0];
      16'h1c84: v = m_sel[1];
      16'h1cf0: v = VER;
      16'h0534: v = {22'd0, m_pm, 9'd0};
      default: begin
        for (int n = 0; n < 8; n++) begin
          if (a == 16'h1d00 + 16'(8 * n))     v = m_cnt[n][31:0];
          if (a == 16'h1d04 + 16'(8 * n))     v = m_cnt[n][63:32];
        end
      end
    endcase
    return v;
  endfunction

  // Reference model update for one clock edge, from the requirements.
  function automatic void model_edge(input bit wr, input bit [15:0] a,
                                     input bit [31:0] d, input bit [255:0] e);
    bit [7:0] wrap = '0;
    bit [7:0] clr = '0;
    for (int n = 0; n < 8; n++) begin
      bit [7:0] code = m_sel[n / 4][8 * (n % 4) +: 8];
      bit hit = (code == 8'd0) ? 1'b1 : e[code];
      bit inc = m_run && m_en[n] && hit;
      if (wr && a == 16'h1d00 + 16'(8 * n))      m_cnt[n][31:0] = d;
      else if (wr && a == 16'h1d04 + 16'(8 * n)) m_cnt[n][63:32] = d;
      else if (inc) begin
        if (m_cnt[n] == 64'hFFFF_FFFF_FFFF_FFFF) wrap[n] = 1'b1;
        m_cnt[n] = m_cnt[n] + 64'd1;
      end
    end
    if (wr && a == 16'h1c7c) clr = d[7:0];
    m_irq = |(m_st & ~m_mask);
    m_st  = (m_st & ~clr) | wrap;
    if (wr) begin
      case (a)
        16'h1c00: m_run  = d[0];
        16'h1c04: m_en   = d[7:0];
        16'h1c70: m_mask = d[7:0];
        16'h1c80: m_sel[0] = d;
        16'h1c84: m_sel[1] = d;
        16'h0534: m_pm   = d[9];
        default: ;
      endcase
    end
  endfunction

  task automatic step(input bit wr, input bit rd, input bit [15:0] a,
                      input bit [31:0] d, input bit [255:0] e, input string tag);
    bit [31:0] exp_rd;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt_in = e;
    exp_rd = model_read(a);
    @(posedge clk);
    model_edge(wr, a, d, e);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R7 irq_o", {63'd0, irq_o}, {63'd0, m_irq});
    if (rd) begin
      chk({tag, " rvalid R1"}, {63'd0, bus_rvalid}, 64'd1);
      chk(tag, {32'd0, bus_rdata}, {32'd0, exp_rd});
    end
  endtask

  task automatic wr(input bit [15:0] a, input bit [31:0] d, input bit [255:0] e = '0);
    step(1'b1, 1'b0, a, d, e, "write");
  endtask

  task automatic rd(input bit [15:0] a, input string tag, input bit [255:0] e = '0);
    step(1'b0, 1'b1, a, 32'd0, e, tag);
  endtask

  task automatic idle(input int cycles, input bit [255:0] e);
    for (int i = 0; i < cycles; i++) step(1'b0, 1'b0, 16'h0, 32'd0, e, "idle");
  endtask

  function automatic bit [255:0] rand_evt();
    bit [255:0] e;
    for (int k = 0; k < 8; k++) e[32 * k +: 32] = $urandom;
    return e;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [255:0] ev;
    void'($urandom(32'd1234));
    for (int n = 0; n < 8; n++) m_cnt[n] = 0;
    m_en = '0; m_mask = 8'hFF; m_st = '0; m_sel[0] = '0; m_sel[1] = '0;
    m_run = 0; m_pm = 0; m_irq = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 irq_o", {63'd0, irq_o}, 64'd0);
    chk("R11 pm_hold_o", {63'd0, pm_hold_o}, 64'd0);
    chk("R11 rvalid", {63'd0, bus_rvalid}, 64'd0);
    rd(16'h1c70, "R11 mask reset");
    rd(16'h1c78, "R11 status reset");
    rd(16'h1d1c, "R11 counter3 hi reset");
    rd(16'h0010, "R11 unmapped read");

    // R10 version is read-only
    wr(16'h1cf0, 32'hDEAD_BEEF);
    rd(16'h1cf0, "R10 version");
    chk("R10 version value", {32'd0, bus_rdata}, {32'd0, VER});

    // R9 power-management override bit
    wr(16'h0534, 32'hFFFF_FFFF);
    rd(16'h0534, "R9 config");
    chk("R9 pm_hold_o", {63'd0, pm_hold_o}, 64'd1);

    // R1 preload and read back both halves
    wr(16'h1d10, 32'h1234_5678);
    wr(16'h1d14, 32'h9ABC_DEF0);
    rd(16'h1d10, "R1 counter2 lo");
    rd(16'h1d14, "R1 counter2 hi");

    // R2/R3 counter 5 selects event 0x21 through bits [15:8] of 0x1c84
    wr(16'h1c84, 32'h0000_2100);
    wr(16'h1c04, 32'h0000_0020);
    wr(16'h1c00, 32'h1);
    ev = '0; ev[8'h21] = 1'b1;
    idle(7, ev);
    idle(3, ~ev);
    wr(16'h1c00, 32'h0);
    rd(16'h1d28, "R3 counter5 counted event 0x21");
    chk("R2 counter5 count", m_cnt[5], 64'd7);

    // R4 frozen when globally disabled
    idle(5, '1);
    rd(16'h1d28, "R4 frozen counter5");

    // R5/R7 wrap of counter 0 counting cycles
    wr(16'h1d00, 32'hFFFF_FFFE);
    wr(16'h1d04, 32'hFFFF_FFFF);
    wr(16'h1c80, 32'h0);
    wr(16'h1c04, 32'h21);
    wr(16'h1c70, 32'hFE);
    wr(16'h1c00, 32'h1);
    idle(4, '0);
    rd(16'h1c78, "R5 status after wrap");
    chk("R5 status bit0", {63'd0, m_st[0]}, 64'd1);
    chk("R7 irq raised", {63'd0, irq_o}, 64'd1);

    // R8 write wins over increment on counter 0
    wr(16'h1d00, 32'h0000_0055);
    wr(16'h1c00, 32'h0);
    rd(16'h1d00, "R8 write priority lo");

    // R6 clear behaviour
    wr(16'h1c7c, 32'h0);
    rd(16'h1c78, "R6 zero write keeps status");
    wr(16'h1c7c, 32'h1);
    rd(16'h1c78, "R6 clear status");
    rd(16'h1c7c, "R6 clear reads zero");
    idle(2, '0);
    chk("R7 irq dropped", {63'd0, irq_o}, 64'd0);

    // Random traffic against the reference model
    for (int it = 0; it < 4000; it++) begin
      int op = $urandom_range(0, 9);
      int n = $urandom_range(0, 7);
      bit [15:0] a;
      ev = rand_evt();
      case (op)
        0: wr(16'h1c00, $urandom, ev);
        1: wr(16'h1c04, $urandom, ev);
        2: wr(16'h1c70, $urandom, ev);
        3: wr(16'h1c7c, $urandom, ev);
        4: wr(16'h1c80 + 16'(4 * (n % 2)), $urandom & 32'h0F0F_0F0F, ev);
        5: begin
          wr(16'h1d04 + 16'(8 * n), 32'hFFFF_FFFF, ev);
          wr(16'h1d00 + 16'(8 * n), 32'hFFFF_FFFF - $urandom_range(0, 40), ev);
        end
        6, 7: begin
          a = 16'h1d00 + 16'(8 * n) + 16'(4 * $urandom_range(0, 1));
          rd(a, "R2 random counter read", ev);
        end
        8: rd(16'h1c78, "R5 random status read", ev);
        default: idle(1, ev);
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule